// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the order of column addresses that a synchronous DRAM walks through during one read or write burst. A controller pulses a start input together with the first column, a burst-length code, an ordering bit and the direction of the access. From the next clock on, the block presents one column per cycle and marks the final beat with a last flag. The supported lengths are 1, 2, 4 and 8 beats, each with sequential or interleaved ordering, plus a full-page mode that walks all 256 columns in a ring until a stop input ends it.

An optional single-write mode shortens every write burst to one beat, while reads keep the programmed length. Burst settings are captured only when a burst starts. A new start that arrives while a burst is running replaces that burst at once. Command issue, mode programming and the data path belong to the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and whenever no burst is active, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: When `start_i` is high at a rising edge, the next cycle shows `valid_o`=1 and `col_o` equal to the `start_col_i` value sampled at that edge.
- R3: Length code `len_code_i` decodes as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and any code with bit 2 set gives full page. A fixed burst of N beats shows `valid_o` for N cycles, raises `last_o` only on the Nth beat, and then goes idle unless a new start arrives.
- R4: With `interleave_i`=0 and a fixed length N, beat k shows the column whose bits above the low log2(N) bits equal the start column's, and whose low bits equal (start low bits + k) mod N.
- R5: With `interleave_i`=1 and a fixed length N, beat k keeps the upper bits of the start column, and its low log2(N) bits equal the start column's low bits XOR k.
- R6: A 1-beat burst shows only the start column, with `valid_o` and `last_o` both high in the same single cycle.
- R7: Full page always counts sequentially, whatever `interleave_i` is. Beat k shows (start + k) mod 256, so it wraps from 255 to 0 and keeps going past 256 beats, and `last_o` never rises.
- R8: In full page, when `stop_i` is high at a rising edge during an active burst, the column shown in that cycle is the final one, and the next cycle is idle.
- R9: `stop_i` has no effect on fixed-length bursts.
- R10: A start that arrives during an active burst aborts it, and the new sequence begins on the next clock. A start takes precedence over a stop at the same edge.
- R11: With `single_write_i`=1 at start, a burst with `is_write_i`=1 is one beat long, and a burst with `is_write_i`=0 uses the coded length. With `single_write_i`=0, writes use the coded length.
- R12: Column, length code, ordering, direction and single-write inputs are sampled only at start. Changing them during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst (sampled at the edge) |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects interleaved ordering |
| is_write_i | input | 1 | 1 marks the burst as a write |
| single_write_i | input | 1 | 1 forces writes to a single beat |
| stop_i | input | 1 | End a full-page burst after the current beat |
| valid_o | output | 1 | A burst beat is presented |
| col_o | output | 8 | Column of the current beat |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench attacks start columns that are not aligned to the burst size. A sequencer that carries into the upper bits, or that adds where it should XOR, shows a column outside the aligned block or in the wrong order. Full-page runs cover the wrap from 255 to 0 and go past 256 beats, with the ordering bit set. A wrong design would stop at 255, raise `last_o`, or switch to interleaved order. The bench also fires stops during fixed bursts, and starts during active bursts, including one at the same edge as a stop. A block that mishandles these ends the burst early, finishes the old sequence, or lets the stop win. It runs writes and reads with the single-write mode on and off, and changes every setting in the middle of a burst, so that settings captured at the wrong time show up at once.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    BCS_LEN1 = 3'd0,
    BCS_LEN2 = 3'd1,
    BCS_LEN4 = 3'd2,
    BCS_LEN8 = 3'd3,
    BCS_PAGE = 3'd7
  } bcs_len_e;

  // Returns a mask of the column bits that change inside a fixed burst.
  function automatic logic [7:0] bcs_len_mask(input logic [2:0] code);
    logic [7:0] m;
    case (code[1:0])
      2'd0:    m = 8'h00;
      2'd1:    m = 8'h01;
      2'd2:    m = 8'h03;
      default: m = 8'h07;
    endcase
    if (code[2]) m = 8'hFF;
    return m;
  endfunction

  // Sequential offset: start plus beat index, with a natural wrap.
  function automatic logic [7:0] bcs_seq_offs(input logic [7:0] base,
                                              input logic [7:0] beat);
    return base + beat;
  endfunction

  // Interleaved offset: start XOR beat index.
  function automatic logic [7:0] bcs_il_offs(input logic [7:0] base,
                                             input logic [7:0] beat);
    return base ^ beat;
  endfunction

endpackage

// File: rtl/bcs_cfg_latch.sv
module bcs_cfg_latch #(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             interleave_i,
  input  logic             is_write_i,
  input  logic             single_write_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             il_o
);
  import bcs_pkg::*;

  logic             force_single;
  logic [COL_W-1:0] mask_dec;
  logic             full_dec;

  assign force_single = single_write_i & is_write_i;
  assign mask_dec     = force_single ? '0 : COL_W'(bcs_len_mask(len_code_i));
  assign full_dec     = ~force_single & len_code_i[LEN_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      mask_o <= '0;
      full_o <= 1'b0;
      il_o   <= 1'b0;
    end else if (start_i) begin
      base_o <= start_col_i;
      mask_o <= mask_dec;
      full_o <= full_dec;
      il_o   <= interleave_i & ~full_dec;
    end
  end

  AST_FULL_IS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !il_o); // R7
  AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && force_single) |=> (mask_o == '0 && !full_o)); // R11
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  logic ev_last_end;
  logic ev_stop_end;
  logic ev_end;

  assign ev_last_end = active_o & ~full_i & (beat_o == mask_i);
  assign ev_stop_end = active_o & full_i & stop_i;
  assign ev_end      = ev_last_end | ev_stop_end;
  assign last_o      = ev_last_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      beat_o   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      beat_o   <= '0;
    end else if (active_o) begin
      if (ev_end) begin
        active_o <= 1'b0;
        beat_o   <= '0;
      end else begin
        beat_o <= beat_o + 1'b1;
      end
    end
  end

  AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_o && beat_o == '0)); // R10
  AST_LAST_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> active_o); // R3
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !active_o); // R3
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && full_i) |-> !last_o); // R7
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && full_i && stop_i && !start_i) |=> !active_o); // R8
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i && !ev_end) |=>
      (active_o && beat_o == $past(beat_o) + 1'b1)); // R4
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             active_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  import bcs_pkg::*;

  logic [COL_W-1:0] offs_seq;
  logic [COL_W-1:0] offs_il;
  logic [COL_W-1:0] offs_sel;
  logic [COL_W-1:0] col_raw;

  assign offs_seq = COL_W'(bcs_seq_offs(8'(base_i), 8'(beat_i)));
  assign offs_il  = COL_W'(bcs_il_offs(8'(base_i), 8'(beat_i)));
  assign offs_sel = il_i ? offs_il : offs_seq;

  for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
    assign col_raw[gi] = mask_i[gi] ? offs_sel[gi] : base_i[gi];
  end

  assign col_o = active_i ? col_raw : '0;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             interleave_i,
  input  logic             is_write_i,
  input  logic             single_write_i,
  input  logic             stop_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [COL_W-1:0] cfg_base;
  logic [COL_W-1:0] cfg_mask;
  logic             cfg_full;
  logic             cfg_il;
  logic             seq_active;
  logic [COL_W-1:0] seq_beat;

  bcs_cfg_latch #(.COL_W(COL_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i),
    .interleave_i(interleave_i), .is_write_i(is_write_i),
    .single_write_i(single_write_i),
    .base_o(cfg_base), .mask_o(cfg_mask), .full_o(cfg_full), .il_o(cfg_il)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .mask_i(cfg_mask), .full_i(cfg_full),
    .active_o(seq_active), .beat_o(seq_beat), .last_o(last_o)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_col (
    .active_i(seq_active), .base_i(cfg_base), .beat_i(seq_beat),
    .mask_i(cfg_mask), .il_i(cfg_il), .col_o(col_o)
  );

  assign valid_o = seq_active;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (col_o == '0 && !last_o)); // R1
  AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R2
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && !$past(start_i) && !cfg_full) |->
      ((col_o & ~cfg_mask) == ($past(col_o) & ~cfg_mask))); // R4
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && single_write_i && is_write_i) |=> last_o); // R11
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic       single_write_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       valid_o;
  logic [7:0] col_o;
  logic       last_o;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_active = 0;
  int m_base = 0, m_beat = 0, m_len = 1;
  bit m_full = 0, m_il = 0;

  always #10 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i),
    .is_write_i(is_write_i), .single_write_i(single_write_i),
    .stop_i(stop_i), .valid_o(valid_o), .col_o(col_o), .last_o(last_o)
  );

  function automatic int code_len(input int code);
    if (code >= 4) return 256;
    return 1 << code;
  endfunction

  function automatic int exp_col();
    int blk, lo;
    if (!m_active) return 0;
    if (m_full) return (m_base + m_beat) % 256;
    blk = (m_base / m_len) * m_len;
    lo  = m_base % m_len;
    if (m_il) return blk + (lo ^ m_beat);
    return blk + ((lo + m_beat) % m_len);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_active = 0;
    end else if (start_i) begin
      m_active = 1;
      m_base = start_col_i;
      m_beat = 0;
      if (single_write_i && is_write_i) begin
        m_len = 1; m_full = 0;
      end else begin
        m_len = code_len(len_code_i);
        m_full = (len_code_i >= 4);
      end
      m_il = interleave_i && !m_full;
    end else if (m_active) begin
      if (m_full) begin
        if (stop_i) m_active = 0;
        else m_beat = (m_beat + 1) % 256;
      end else if (m_beat == m_len - 1) m_active = 0;
      else m_beat = m_beat + 1;
    end
  end

  always @(negedge clk) begin
    int e_col;
    bit e_last;
    if (!done) begin
      e_col  = exp_col();
      e_last = m_active && !m_full && (m_beat == m_len - 1);
      n_checks++;
      if (valid_o !== m_active || last_o !== e_last || int'(col_o) != e_col) begin
        n_fail++;
        $display("FAIL %s cyc %0d: valid/col/last actual %0b/%0d/%0b expected %0b/%0d/%0b",
                 rst_n ? cur_req : "R1", cyc, valid_o, col_o, last_o,
                 m_active, e_col, e_last);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected end before 50000", cyc);
      finish_run();
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input int col, input int code, input bit il,
                    input bit wr, input bit sw);
    @(negedge clk);
    start_i = 1; start_col_i = 8'(col); len_code_i = 3'(code);
    interleave_i = il; is_write_i = wr; single_write_i = sw;
    @(negedge clk);
    start_i = 0;
  endtask

  initial begin
    cur_req = "R1";
    wait_neg(4);
    rst_n = 1;
    wait_neg(3);
    // R4 sequential, unaligned starts
    cur_req = "R4";
    go(8'h35, 1, 0, 0, 0); wait_neg(3);
    go(8'h36, 2, 0, 0, 0); wait_neg(5);
    go(8'h8D, 3, 0, 0, 0); wait_neg(9);
    // R5 interleaved
    cur_req = "R5";
    go(8'h13, 1, 1, 0, 0); wait_neg(3);
    go(8'h42, 2, 1, 0, 0); wait_neg(5);
    go(8'hE5, 3, 1, 0, 0); wait_neg(9);
    // R6 single beat
    cur_req = "R6";
    go(8'hFF, 0, 1, 0, 0); wait_neg(3);
    // R2 R3 back-to-back starts at last beat
    cur_req = "R3";
    go(8'h07, 3, 0, 0, 0); wait_neg(6);
    go(8'h10, 2, 0, 0, 0); wait_neg(5);
    go(8'h20, 5, 0, 0, 0); wait_neg(4);
    stop_i = 1; @(negedge clk); stop_i = 0; wait_neg(2);
    // R7 full page wrap past 256 beats, interleave requested
    cur_req = "R7";
    go(8'hFA, 7, 1, 0, 0); wait_neg(300);
    // R8 stop
    cur_req = "R8";
    stop_i = 1; @(negedge clk); stop_i = 0; wait_neg(3);
    // R9 stop during fixed burst
    cur_req = "R9";
    go(8'h50, 3, 0, 0, 0); wait_neg(2);
    stop_i = 1; wait_neg(3); stop_i = 0; wait_neg(5);
    // R10 abort with new start, and start beating stop
    cur_req = "R10";
    go(8'h60, 3, 0, 0, 0); wait_neg(2);
    go(8'h9B, 2, 1, 0, 0); wait_neg(6);
    go(8'h00, 7, 0, 0, 0); wait_neg(5);
    @(negedge clk); start_i = 1; stop_i = 1; start_col_i = 8'hC3;
    len_code_i = 3'd1; interleave_i = 0;
    @(negedge clk); start_i = 0; stop_i = 0; wait_neg(4);
    // R11 single write
    cur_req = "R11";
    go(8'h71, 3, 0, 1, 1); wait_neg(3);
    go(8'h71, 3, 0, 0, 1); wait_neg(9);
    go(8'h71, 2, 1, 1, 0); wait_neg(5);
    go(8'h71, 7, 0, 1, 1); wait_neg(3);
    // R12 settings changed mid burst
    cur_req = "R12";
    go(8'hA9, 3, 1, 0, 0);
    start_col_i = 8'h00; len_code_i = 3'd7; interleave_i = 0;
    is_write_i = 1; single_write_i = 1;
    wait_neg(10);
    cur_req = "R1";
    wait_neg(3);
    finish_run();
  end
endmodule